// File: doc/BRIEF.md
# Watchdog Timer with Prescaler Clear

This block is the watchdog of a small microcontroller core. A power-of-two prescaler divides the core clock. Each prescaler terminal count advances an 8-bit watchdog counter. When that counter rolls over from its top value, the block issues a single-cycle reset request and lowers its time-out flag, so the firmware can later tell a watchdog reset from a power-up.

Firmware keeps the watchdog quiet by executing its clear-watchdog instruction, which the core presents here as a one-cycle strobe. The strobe zeroes the counter and the prescaler together and raises both status flags. The core's sleep-entry strobe also restarts the count, but it lowers the power-down flag. Dropping the enable parks the counting chain at zero.

Top module: `wdog_timer`

## Requirements
- R1: While the synchronous reset is high, and on the first cycle after it, `to_flag` is 1, `pd_flag` is 1 and `wdt_reset_req` is 0.
- R2: With `wdt_en` high and `presc_sel` = s (0 to 7), the prescaler divides by 2^s. `wdt_reset_req` first reads 1 after the (256·2^s)-th rising edge that follows the edge sampling a clear strobe.
- R3: `wdt_reset_req` stays high for exactly one cycle. `to_flag` reads 0 from that same edge onward.
- R4: A clear strobe zeroes both the counter and the prescaler. After a clear given in the middle of a count, the next request still needs a full 256·2^s edges.
- R5: A clear strobe sets `to_flag` and `pd_flag` to 1 on the next edge, whatever the state of `wdt_en`.
- R6: A sleep strobe without a clear sets `to_flag` to 1 and `pd_flag` to 0, and restarts the count from zero the same way a clear does.
- R7: When the clear and sleep strobes arrive in the same cycle, the clear wins: both flags become 1.
- R8: While `wdt_en` is low, no request is issued and the counter and prescaler are held at zero. After `wdt_en` rises, the first request needs a full 256·2^s enabled edges.
- R9: Overflow does not stop the count. Requests repeat every 256·2^s edges, `to_flag` stays 0 between them, and overflow never changes `pd_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wdt_en | input | 1 | Watchdog enable |
| clr_wdt | input | 1 | Clear-watchdog instruction strobe |
| sleep_enter | input | 1 | Sleep-entry strobe |
| presc_sel | input | SEL_W | Prescaler exponent; divide by 2^presc_sel |
| wdt_reset_req | output | 1 | One-cycle reset request on overflow |
| to_flag | output | 1 | Time-out status; 0 after a watchdog overflow |
| pd_flag | output | 1 | Power-down status; 0 after sleep entry |

## Verification
All three outputs are registers. A strobe applied before edge E is therefore visible in the flags directly after E. A rollover is visible in the request exactly 256·2^s edges after the restarting edge. The bench drives and samples on falling edges and counts falling edges from the one that follows the restarting edge, so the count it reads equals the number of rising edges exactly. Every select value is swept. The same period is then measured again after a mid-count clear, after sleep entry, after a disabled stretch, and for a second consecutive rollover.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // What the watchdog chain does this cycle, in priority order
  typedef enum logic [1:0] {
    WD_CLEAR = 2'd0,  // clear instruction: restart, both flags set
    WD_SLEEP = 2'd1,  // sleep entry: restart, power-down flag low
    WD_IDLE  = 2'd2,  // disabled: chain parked at zero
    WD_RUN   = 2'd3   // counting
  } wd_act_e;

  function automatic wd_act_e wd_decode(input logic clr, input logic slp,
                                        input logic en);
    if (clr)      return WD_CLEAR;
    else if (slp) return WD_SLEEP;
    else if (!en) return WD_IDLE;
    else          return WD_RUN;
  endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] limit;

  // Terminal value is 2^sel - 1
  assign limit = ~({PRE_W{1'b1}} << sel);
  assign tick  = run && (pre_q == limit);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) pre_q <= '0;
    else                     pre_q <= pre_q + 1'b1;
  end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic wrap
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  assign wrap = tick && (cnt_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (tick)   cnt_q <= cnt_q + 1'b1;  // rolls to zero on wrap
  end

endmodule

// File: rtl/wdt_status.sv
module wdt_status
  import wdt_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  wd_act_e act,
  input  logic    wrap,
  output logic    req_q,
  output logic    to_q,
  output logic    pd_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      to_q  <= 1'b1;
      pd_q  <= 1'b1;
    end else begin
      req_q <= 1'b0;
      unique case (act)
        WD_CLEAR: begin
          to_q <= 1'b1;
          pd_q <= 1'b1;
        end
        WD_SLEEP: begin
          to_q <= 1'b1;
          pd_q <= 1'b0;
        end
        WD_RUN: begin
          if (wrap) begin
            req_q <= 1'b1;
            to_q  <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdt_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wdt_en,
  input  logic             clr_wdt,
  input  logic             sleep_enter,
  input  logic [SEL_W-1:0] presc_sel,
  output logic             wdt_reset_req,
  output logic             to_flag,
  output logic             pd_flag
);

  wd_act_e act;
  logic    run;
  logic    tick;
  logic    wrap;

  always_comb begin
    act = wd_decode(clr_wdt, sleep_enter, wdt_en);
    run = (act == WD_RUN);
  end

  wdt_prescaler #(.SEL_W(SEL_W)) i_pre (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .sel  (presc_sel),
    .tick (tick)
  );

  wdt_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .tick (tick),
    .wrap (wrap)
  );

  wdt_status i_stat (
    .clk   (clk),
    .rst   (rst),
    .act   (act),
    .wrap  (wrap),
    .req_q (wdt_reset_req),
    .to_q  (to_flag),
    .pd_q  (pd_flag)
  );

endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk (
  input logic clk,
  input logic rst,
  input logic wdt_en,
  input logic clr_wdt,
  input logic sleep_enter,
  input logic wdt_reset_req,
  input logic to_flag,
  input logic pd_flag
);

  // R3
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wdt_reset_req |=> !wdt_reset_req);

  // R3
  req_to_low_chk: assert property (@(posedge clk) disable iff (rst)
    wdt_reset_req |-> !to_flag);

  // R9
  to_fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(to_flag) |-> wdt_reset_req);

  // R5
  clear_flags_chk: assert property (@(posedge clk) disable iff (rst)
    clr_wdt |=> (to_flag && pd_flag));

  // R6
  sleep_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (sleep_enter && !clr_wdt) |=> (to_flag && !pd_flag));

  // R8
  idle_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    !wdt_en |=> !wdt_reset_req);

  // R4
  restart_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_wdt || sleep_enter) |=> !wdt_reset_req);

  // R9
  pd_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_flag) |-> $past(clr_wdt));

endmodule

bind wdog_timer wdog_timer_chk i_wdog_chk (
  .clk           (clk),
  .rst           (rst),
  .wdt_en        (wdt_en),
  .clr_wdt       (clr_wdt),
  .sleep_enter   (sleep_enter),
  .wdt_reset_req (wdt_reset_req),
  .to_flag       (to_flag),
  .pd_flag       (pd_flag)
);

// File: tb/test_wdog_timer.sv
`timescale 1ns/1ps
module test_wdog_timer;

  localparam int SEL_W = 3;
  localparam int LIMIT = (256 << 7) + 16;

  logic clk = 1'b0;
  logic rst, wdt_en, clr_wdt, sleep_enter;
  logic [SEL_W-1:0] presc_sel;
  logic wdt_reset_req, to_flag, pd_flag;

  int checks = 0;
  int fails  = 0;
  bit timed_out = 1'b0;

  always #2.5 clk = ~clk;

  wdog_timer #(.CNT_W(8), .SEL_W(SEL_W)) i_wdog_timer (
    .clk           (clk),
    .rst           (rst),
    .wdt_en        (wdt_en),
    .clr_wdt       (clr_wdt),
    .sleep_enter   (sleep_enter),
    .presc_sel     (presc_sel),
    .wdt_reset_req (wdt_reset_req),
    .to_flag       (to_flag),
    .pd_flag       (pd_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_clear();
    clr_wdt = 1'b1;
    @(negedge clk);
    clr_wdt = 1'b0;
  endtask

  task automatic pulse_sleep();
    sleep_enter = 1'b1;
    @(negedge clk);
    sleep_enter = 1'b0;
  endtask

  // Falling edges until the request is seen; equals the rising edges elapsed
  task automatic measure(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!wdt_reset_req && n < LIMIT);
  endtask

  task automatic run_all();
    int n;
    int seen;
    rst = 1'b1; wdt_en = 1'b0; clr_wdt = 1'b0; sleep_enter = 1'b0;
    presc_sel = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 to", int'(to_flag), 1);
    chk("R1 pd", int'(pd_flag), 1);
    chk("R1 req", int'(wdt_reset_req), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 req after release", int'(wdt_reset_req), 0);
    wdt_en = 1'b1;

    // R2 / R3: sweep every prescaler select
    for (int s = 0; s < 8; s++) begin
      presc_sel = SEL_W'(s);
      pulse_clear();
      chk("R5 to after clear", int'(to_flag), 1);
      measure(n);
      chk("R2 period", n, 256 << s);
      chk("R3 to low with req", int'(to_flag), 0);
      @(negedge clk);
      chk("R3 single-cycle req", int'(wdt_reset_req), 0);
      chk("R3 to stays low", int'(to_flag), 0);
    end

    // R5 clear after timeout restores both flags
    pulse_clear();
    chk("R5 to", int'(to_flag), 1);
    chk("R5 pd", int'(pd_flag), 1);

    // R4 mid-count clear restarts counter and prescaler
    presc_sel = 3'd2;
    pulse_clear();
    repeat (4 * 100 + 2) @(negedge clk);
    pulse_clear();
    measure(n);
    chk("R4 full period after mid clear", n, 1024);

    // R9 repeated overflow
    measure(n);
    chk("R9 second period", n, 1024);
    chk("R9 to stays low", int'(to_flag), 0);
    chk("R9 pd unaffected", int'(pd_flag), 1);

    // R6 sleep entry
    presc_sel = 3'd1;
    pulse_sleep();
    chk("R6 to", int'(to_flag), 1);
    chk("R6 pd", int'(pd_flag), 0);
    measure(n);
    chk("R6 period after sleep", n, 512);
    chk("R9 pd kept low by overflow", int'(pd_flag), 0);

    // R7 simultaneous strobes
    clr_wdt = 1'b1; sleep_enter = 1'b1;
    @(negedge clk);
    clr_wdt = 1'b0; sleep_enter = 1'b0;
    chk("R7 to", int'(to_flag), 1);
    chk("R7 pd", int'(pd_flag), 1);

    // R8 disable parks the chain
    presc_sel = 3'd0;
    pulse_clear();
    repeat (200) @(negedge clk);
    wdt_en = 1'b0;
    seen = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (wdt_reset_req) seen++;
    end
    chk("R8 no req while disabled", seen, 0);
    chk("R8 to held", int'(to_flag), 1);
    pulse_sleep();
    chk("R6 sleep while disabled pd", int'(pd_flag), 0);
    pulse_clear();
    chk("R5 clear while disabled pd", int'(pd_flag), 1);
    wdt_en = 1'b1;
    measure(n);
    chk("R8 full period after enable", n, 256);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog: actual expired expected finished");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule